// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master. Two programmable counts set the length of the low phase and the high phase in prescaler ticks. Each count is nine bits wide. A software-visible byte holds the lower eight bits, and a separate control bit holds the top bit. The prescaler tick runs at the module clock rate, or at half that rate when `divBy2` is set.

The low phase is timed from the edge on which the block starts to pull SCL low. The high phase is timed only after the synchronised SCL input is seen high. A slave that holds SCL low therefore lengthens the high phase rather than eating into it. The first high phase after `enable` rises is timed the same way, so the high count also sets the hold time after a START condition before the first falling edge of SCL.

For the bit engine, the block pulses one strobe on the last cycle of each low phase, which is the moment to change SDA. It pulses a second strobe near the middle of each high phase, which is the moment to sample SDA.

Top module: `sclTimingGen`

## Requirements
- R1: During and after reset with `enable` low, `sclDriveLow`, `endLowStb` and `midHighStb` are all 0.
- R2: A low phase keeps `sclDriveLow` at 1 for exactly E_L cycles when `divBy2` is 0. E_L is the nine-bit count {`lowCntTop`, `lowCntByte`}, where `lowCntTop` is bit 8, so the ceiling is 511.
- R3: The high phase starts counting only after the SCL input has passed a two-flop synchroniser and reads high. The time with SCL released between two low phases is 3 + E_H·D cycles. E_H is {`highCntTop`, `highCntByte`}, D is 1 or 2, and the formula holds for low phases of at least 2 cycles.
- R4: A count of zero behaves as a count of one.
- R5: With `divBy2` set to 1, every phase takes twice as many module-clock cycles (D = 2).
- R6: After `enable` rises, `sclDriveLow` first reads 1 E_H·D + 2 cycles after the cycle in which `enable` was set. This is the START hold time.
- R7: While an external device holds SCL low after release, the high phase does not advance. Holding SCL low for S extra cycles makes the released time S + 3 + E_H·D.
- R8: `endLowStb` pulses once per low phase, on its last cycle (cycle E_L·D of the phase). `sclDriveLow` is 0 in the following cycle.
- R9: `midHighStb` pulses once per high phase, on the tick at which the high counter equals (E_H−1)>>1. That is cycle 3 + S + ((E_H−1)>>1)·D + D after release.
- R10: Dropping `enable` during a low phase does not shorten it. After that phase ends, SCL stays released and is never driven low again until `enable` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the SCL generator |
| divBy2 | input | 1 | Tick at half the module clock when 1 |
| lowCntByte | input | 8 | Low-phase count, bits 7..0 |
| lowCntTop | input | 1 | Low-phase count, bit 8 |
| highCntByte | input | 8 | High-phase count, bits 7..0 |
| highCntTop | input | 1 | High-phase count, bit 8 |
| sclIn | input | 1 | SCL level sensed on the bus |
| sclDriveLow | output | 1 | 1 pulls SCL low (open-drain enable) |
| endLowStb | output | 1 | Last cycle of a low phase |
| midHighStb | output | 1 | Mid-point tick of a high phase |

## Verification
The bench builds the block with its default parameters: an eight-bit count byte, which gives nine-bit counts, and a two-stage synchroniser. With these values the top count bit is reachable through both low and high counts, up to the 511 ceiling. The fixed three-cycle release-to-count latency lets the bench predict every phase edge exactly. Both prescaler ratios, zero counts and a slave stretch of several cycles are driven, and the strobe positions are measured inside each phase.

// File: rtl/sclTimingPkg.sv
package sclTimingPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAITHI = 2'd1,
    ST_HIGH   = 2'd2,
    ST_LOW    = 2'd3
  } sclState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;   // restart counter and prescaler phase
    logic selHigh;   // compare against the high-phase limit
    logic countOn;   // a timed phase is running
  } ctrlStb_t;

endpackage

// File: rtl/sclTimingDp.sv
module sclTimingDp
  import sclTimingPkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic             divBy2,
  input  logic             sclIn,
  output logic             tick,
  output logic             cntLast,
  output logic             cntMid,
  output logic             sclSync
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] limSel;
  logic [CNT_W-1:0] limEff;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] midIdx;
  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic [SYNC_STAGES-1:0] syncQ;

  // Input synchroniser, idles high like the released bus
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= sclIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate
  assign sclSync = syncQ[SYNC_STAGES-1];

  // Prescaler: phase restarts with each counter load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tog <= 1'b0;
    else if (stb.loadCnt) tog <= 1'b0;
    else if (divBy2)      tog <= ~tog;
    else                  tog <= 1'b0;
  end
  assign tick = divBy2 ? tog : 1'b1;

  // Limit selection; a zero count behaves as one
  always_comb begin
    limSel  = stb.selHigh ? highCnt : lowCnt;
    limEff  = (limSel == '0) ? ONE : limSel;
    lastIdx = limEff - ONE;
    midIdx  = lastIdx >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cnt <= '0;
    else if (stb.loadCnt)                     cnt <= '0;
    else if (stb.countOn && tick && !cntLast) cnt <= cnt + ONE;
  end

  assign cntLast = (cnt == lastIdx);
  assign cntMid  = (cnt == midIdx);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.countOn |-> cnt <= lastIdx);

  // R5
  tick_pace_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divBy2 && tick) |=> (!tick || !divBy2));

endmodule

// File: rtl/sclTimingCtrl.sv
module sclTimingCtrl
  import sclTimingPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     tick,
  input  logic     cntLast,
  input  logic     cntMid,
  input  logic     sclSync,
  output ctrlStb_t stb,
  output logic     sclDriveLow,
  output logic     endLowStb,
  output logic     midHighStb
);

  sclState_e state, nxt;
  logic      phaseEnd;

  assign phaseEnd = tick & cntLast;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (enable) nxt = ST_WAITHI;
      ST_WAITHI: if (!enable) nxt = ST_IDLE;
                 else if (sclSync) nxt = ST_HIGH;
      ST_HIGH:   if (phaseEnd) nxt = enable ? ST_LOW : ST_IDLE;
      ST_LOW:    if (phaseEnd) nxt = enable ? ST_WAITHI : ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb.loadCnt = (nxt != state) && (nxt == ST_HIGH || nxt == ST_LOW);
    stb.selHigh = (state == ST_HIGH);
    stb.countOn = (state == ST_HIGH) || (state == ST_LOW);
  end

  assign sclDriveLow = (state == ST_LOW);
  assign endLowStb   = (state == ST_LOW) && phaseEnd;
  assign midHighStb  = (state == ST_HIGH) && tick && cntMid;

  // R8
  endlow_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    endLowStb |=> !sclDriveLow);

  // R9
  midhigh_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    midHighStb |-> !sclDriveLow);

  // R10
  fall_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> $past(enable));

  // R3
  high_after_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITHI && !sclSync) |=> (state != ST_HIGH));

endmodule

// File: rtl/sclTimingGen.sv
module sclTimingGen
  import sclTimingPkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              divBy2,
  input  logic [BYTE_W-1:0] lowCntByte,
  input  logic              lowCntTop,
  input  logic [BYTE_W-1:0] highCntByte,
  input  logic              highCntTop,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              endLowStb,
  output logic              midHighStb
);

  localparam int CNT_W = BYTE_W + 1;

  ctrlStb_t         stb;
  logic             tick, cntLast, cntMid, sclSync;
  logic [CNT_W-1:0] lowCnt, highCnt;

  assign lowCnt  = {lowCntTop, lowCntByte};
  assign highCnt = {highCntTop, highCntByte};

  sclTimingDp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .lowCnt(lowCnt), .highCnt(highCnt),
    .divBy2(divBy2), .sclIn(sclIn), .tick(tick), .cntLast(cntLast),
    .cntMid(cntMid), .sclSync(sclSync)
  );

  sclTimingCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .cntLast(cntLast),
    .cntMid(cntMid), .sclSync(sclSync), .stb(stb), .sclDriveLow(sclDriveLow),
    .endLowStb(endLowStb), .midHighStb(midHighStb)
  );

endmodule

// File: tb/sclTimingGen_test.sv
`timescale 1ns/1ps
module sclTimingGen_test;

  logic       clk = 1'b0;
  logic       rstN, enable, divBy2, lowCntTop, highCntTop, slaveHold;
  logic [7:0] lowCntByte, highCntByte;
  logic       sclIn, sclDriveLow, endLowStb, midHighStb;
  int         total = 0;
  int         fails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  assign sclIn = ~(sclDriveLow | slaveHold);

  sclTimingGen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divBy2(divBy2),
    .lowCntByte(lowCntByte), .lowCntTop(lowCntTop),
    .highCntByte(highCntByte), .highCntTop(highCntTop),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow), .endLowStb(endLowStb),
    .midHighStb(midHighStb)
  );

  // Vectors: low count, high count, divide-by-2
  localparam int NV = 7;
  localparam int VLOW [NV] = '{5, 3, 256, 6, 0, 2, 511};
  localparam int VHIGH[NV] = '{4, 7, 2, 256, 3, 0, 255};
  localparam int VDIV [NV] = '{0, 1, 0, 0, 1, 0, 0};

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effc(int c);
    return (c == 0) ? 1 : c;
  endfunction

  // Run one period after start; stretch = extra held cycles after release
  task automatic runCase(int lc, int hc, int dv, int stretch, string tag);
    int d, el, eh, n, k, eIdx, eCnt, mIdx, mCnt;
    d  = dv ? 2 : 1;
    el = effc(lc);
    eh = effc(hc);
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    lowCntByte  = lc[7:0]; lowCntTop  = lc[8];
    highCntByte = hc[7:0]; highCntTop = hc[8];
    divBy2 = dv[0];
    @(negedge clk);
    enable = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sclDriveLow && n < 3000);
    chk({tag, " R6 start hold"}, n, eh * d + 2);
    if (stretch > 0) slaveHold = 1'b1;
    // low phase
    k = 0; eIdx = 0; eCnt = 0;
    while (sclDriveLow && k < 3000) begin
      k++;
      if (endLowStb) begin eIdx = k; eCnt++; end
      @(negedge clk);
    end
    chk({tag, " R2 low length"}, k, el * d);
    chk({tag, " R8 endLow position"}, eIdx, el * d);
    chk({tag, " R8 endLow count"}, eCnt, 1);
    // high phase
    k = 0; mIdx = 0; mCnt = 0;
    while (!sclDriveLow && k < 3000) begin
      k++;
      if (stretch > 0 && k == stretch + 1) slaveHold = 1'b0;
      if (midHighStb) begin mIdx = k; mCnt++; end
      @(negedge clk);
    end
    chk({tag, " R3 R7 high length"}, k, stretch + 3 + eh * d);
    chk({tag, " R9 midHigh position"}, mIdx,
        3 + stretch + ((eh - 1) >> 1) * d + d);
    chk({tag, " R9 midHigh count"}, mCnt, 1);
    // drop enable on first low cycle
    enable = 1'b0;
    k = 0;
    while (sclDriveLow && k < 3000) begin k++; @(negedge clk); end
    chk({tag, " R10 last low full"}, k, el * d);
    n = 0;
    repeat (60) begin
      if (sclDriveLow) n++;
      @(negedge clk);
    end
    chk({tag, " R10 stays released"}, n, 0);
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; divBy2 = 1'b0; slaveHold = 1'b0;
    lowCntByte = 8'd4; lowCntTop = 1'b0; highCntByte = 8'd4; highCntTop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset drive", {31'd0, sclDriveLow}, 0);
    chk("R1 reset strobes", {30'd0, endLowStb, midHighStb}, 0);
    rstN = 1'b1;
    begin
      int seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (sclDriveLow || endLowStb || midHighStb) seen++;
      end
      chk("R1 idle after reset", seen, 0);
    end
    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("vec%0d", i);
      runCase(VLOW[i], VHIGH[i], VDIV[i], 0, t);
    end
    // zero counts and divide-by-2 corner cases
    runCase(0, 0, 1, 0, "R4 R5 both zero");
    // clock stretching by a slave
    runCase(4, 3, 0, 6, "R7 stretch");
    runCase(3, 5, 1, 4, "R7 R5 stretch div2");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule